// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block lives inside an SDRAM controller. It decides when a write request may reach the command bus while a read burst is still returning data, or has only just stopped returning it. It takes read requests, each with a bank, a column and a beat count. It takes write requests, each with a bank, a column and one data word. It drives the command lines, the bank and column address, the data mask and the controller's own data-output enable.

When a write arrives and read data could still be on the bus, the block raises the data mask early enough that the memory goes quiet before the write. It then cuts the read burst short with the WRITE command. The mask reaches the read output path two clocks late but reaches write data at once, so the mask is dropped on the WRITE cycle itself. An optional turnaround setting adds one more quiet cycle between the last read beat and the write data, for systems whose drivers switch slowly. If the read window has already closed, the write goes out on the next cycle with no preamble.

Top module: `sdram_turnaround_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `cmd` is NOP, `dqm` is 0, `dq_oe` is 0 and `idle` is 1.
- R2: `cmd` is {cs_n, ras_n, cas_n, we_n}. NOP is 4'b0111, READ is 4'b0101 and WRITE is 4'b0100. No other value ever appears. A read request sampled while `idle` is 1 gives READ on the next cycle, with `ba` and `col` taken from the request.
- R3: A write request sampled in cycle t gives WRITE in cycle t+1 if read data can no longer reach the bus. Without turnaround this means the last read beat is at or before cycle t. With turnaround it means the last read beat is before cycle t.
- R4: Otherwise, with `turn_gap`=0, `dqm` is 1 in cycles t+1 and t+2, with NOP on the bus, and WRITE comes in cycle t+3. Every WRITE that cuts a read window short has `dqm` high on both of the two cycles before it.
- R5: Otherwise, with `turn_gap`=1, `dqm` is 1 in cycles t+1 to t+3, with NOP on the bus, and WRITE comes in cycle t+4.
- R6: `dqm` is 0 on every WRITE cycle. `dq_oe` is 1 only on a WRITE cycle, and `dq_out` then carries the request's data.
- R7: A read beat is driven in cycle READ+CL+k, for k from 0 to length-1, unless `dqm` was high two cycles earlier. No such beat coincides with `dq_oe`. With `turn_gap`=1, no such beat falls in the cycle just before `dq_oe`.
- R8: CAS latency is 3 when `cas3`=1 and 2 when `cas3`=0. The preamble length in R4 and R5 does not depend on it.
- R9: A write request has priority over a read request in the same cycle. While a write waits in its preamble, `idle` is 0 and read and write requests are ignored.
- R10: The bank of the WRITE may differ from that of the READ. `ba` and `col` on the WRITE cycle are those of the write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request, sampled when idle |
| rd_bank | input | BW | Read bank |
| rd_col | input | CW | Read column |
| rd_len | input | LW | Read burst length in beats |
| wr_req | input | 1 | Write request |
| wr_bank | input | BW | Write bank |
| wr_col | input | CW | Write column |
| wr_data | input | DW | Write data word |
| cas3 | input | 1 | 1: CAS latency 3, 0: CAS latency 2 |
| turn_gap | input | 1 | 1: add one idle bus cycle before write data |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ba | output | BW | Bank address |
| col | output | CW | Column address |
| dqm | output | 1 | Data mask |
| dq_oe | output | 1 | Controller data-output enable |
| dq_out | output | DW | Controller write data |
| idle | output | 1 | No write is waiting in a preamble |

## Verification
The bench places a write request at several distances from the end of a read window, under both CAS latencies and both turnaround settings. The most telling cases are the request on the last read beat and the request one cycle after it. There the direct path and the preamble path meet: a design with an off-by-one busy count would either send a direct write that collides with the final beat, or add a needless preamble. A pin model of the memory flags any cycle in which the memory and the controller both drive the bus. It also flags any truncating WRITE that lacks mask on the two cycles before it, so a preamble one cycle too short is caught. Directed tests cover requests that collide in one cycle, requests made during a preamble, and a reset taken in the middle of a preamble.

// File: rtl/sdram_turnaround_seq.sv
module sdram_turnaround_seq #(
  parameter int BW = 2,
  parameter int CW = 9,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [BW-1:0] rd_bank,
  input  logic [CW-1:0] rd_col,
  input  logic [LW-1:0] rd_len,
  input  logic          wr_req,
  input  logic [BW-1:0] wr_bank,
  input  logic [CW-1:0] wr_col,
  input  logic [DW-1:0] wr_data,
  input  logic          cas3,
  input  logic          turn_gap,
  output logic [3:0]    cmd,
  output logic [BW-1:0] ba,
  output logic [CW-1:0] col,
  output logic          dqm,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          idle
);
  localparam int CNTW = LW + 2;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;

  logic [CNTW-1:0] busy_q, rd_span;
  logic            pend_q, quiet;
  logic [1:0]      pre_q;
  logic [BW-1:0]   wb_q;
  logic [CW-1:0]   wc_q;
  logic [DW-1:0]   wd_q;

  assign rd_span = CNTW'(rd_len) + (cas3 ? CNTW'(3) : CNTW'(2));
  assign quiet   = turn_gap ? (busy_q == '0) : (busy_q <= CNTW'(1));
  assign idle    = !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= CMD_NOP;
      ba     <= '0;
      col    <= '0;
      dqm    <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
      busy_q <= '0;
      pend_q <= 1'b0;
      pre_q  <= '0;
      wb_q   <= '0;
      wc_q   <= '0;
      wd_q   <= '0;
    end else begin
      cmd    <= CMD_NOP;
      dqm    <= 1'b0;
      dq_oe  <= 1'b0;
      busy_q <= (busy_q != '0) ? busy_q - CNTW'(1) : '0;
      if (pend_q) begin
        if (pre_q != 2'd0) begin
          dqm   <= 1'b1;
          pre_q <= pre_q - 2'd1;
        end else begin
          cmd    <= CMD_WR;
          ba     <= wb_q;
          col    <= wc_q;
          dq_out <= wd_q;
          dq_oe  <= 1'b1;
          pend_q <= 1'b0;
          busy_q <= '0;
        end
      end else if (wr_req) begin
        if (quiet) begin
          cmd    <= CMD_WR;
          ba     <= wr_bank;
          col    <= wr_col;
          dq_out <= wr_data;
          dq_oe  <= 1'b1;
          busy_q <= '0;
        end else begin
          pend_q <= 1'b1;
          pre_q  <= turn_gap ? 2'd2 : 2'd1;
          dqm    <= 1'b1;
          wb_q   <= wr_bank;
          wc_q   <= wr_col;
          wd_q   <= wr_data;
        end
      end else if (rd_req) begin
        cmd    <= CMD_RD;
        ba     <= rd_bank;
        col    <= rd_col;
        busy_q <= rd_span;
      end
    end
  end

  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) || (cmd == CMD_RD) || (cmd == CMD_WR));

  p_preamble_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cmd == CMD_NOP) && dqm && !dq_oe);

  p_mask_before_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (cmd == CMD_WR) && !dqm && $past(dqm) && $past(dqm, 2));

  p_oe_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == CMD_WR) && !dqm);

  p_oe_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR) |-> dq_oe);
endmodule

// File: tb/sdram_turnaround_seq_test.sv
`timescale 1ns/1ps
module sdram_turnaround_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 0, wr_req = 0, cas3 = 0, turn_gap = 0;
  logic [1:0] rd_bank = 0, wr_bank = 0;
  logic [8:0] rd_col = 0, wr_col = 0;
  logic [3:0] rd_len = 4'd1;
  logic [15:0] wr_data = 0;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [8:0] col;
  logic dqm, dq_oe, idle;
  logic [15:0] dq_out;

  int total = 0, bad = 0;
  int cyc = 0, rd_s = 0, rd_e = 0, contention = 0, invalid = 0, oe_err = 0;
  bit rd_act = 0, drv_prev = 0, dqm_p1 = 0, dqm_p2 = 0, mem_drv;

  localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, WR = 4'b0100;
  // {cas3, turn_gap, len, delay from READ to write request, expected WRITE latency}
  localparam logic [12:0] VEC [12] = '{
    {1'b1,1'b0,4'd4,4'd0,3'd3}, {1'b1,1'b1,4'd4,4'd0,3'd4},
    {1'b0,1'b0,4'd1,4'd0,3'd3}, {1'b0,1'b0,4'd1,4'd2,3'd1},
    {1'b0,1'b1,4'd1,4'd2,3'd4}, {1'b0,1'b1,4'd1,4'd3,3'd1},
    {1'b1,1'b0,4'd8,4'd5,3'd3}, {1'b1,1'b0,4'd2,4'd4,3'd1},
    {1'b1,1'b1,4'd2,4'd5,3'd1}, {1'b0,1'b0,4'd8,4'd9,3'd1},
    {1'b1,1'b1,4'd8,4'd1,3'd4}, {1'b0,1'b1,4'd2,4'd3,3'd4}
  };

  sdram_turnaround_seq uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_bank(rd_bank), .rd_col(rd_col),
    .rd_len(rd_len), .wr_req(wr_req), .wr_bank(wr_bank), .wr_col(wr_col),
    .wr_data(wr_data), .cas3(cas3), .turn_gap(turn_gap), .cmd(cmd), .ba(ba),
    .col(col), .dqm(dqm), .dq_oe(dq_oe), .dq_out(dq_out), .idle(idle));

  always #2.5 clk = ~clk;

  // pin model of the memory, one evaluation per cycle
  always @(negedge clk) if (rst_n) begin
    cyc = cyc + 1;
    mem_drv = rd_act && cyc >= rd_s && cyc <= rd_e && !dqm_p2;
    if (mem_drv && dq_oe) contention = contention + 1;
    if (dq_oe && turn_gap && drv_prev) contention = contention + 1;
    if (dq_oe && (cmd != WR || dqm)) oe_err = oe_err + 1;
    if (cmd == WR) begin
      if (rd_act && rd_e >= cyc && (!dqm_p1 || !dqm_p2)) invalid = invalid + 1;
      rd_act = 0;
    end
    if (cmd == RD) begin
      rd_act = 1;
      rd_s = cyc + (cas3 ? 3 : 2);
      rd_e = rd_s + int'(rd_len) - 1;
    end
    dqm_p2 = dqm_p1; dqm_p1 = dqm; drv_prev = mem_drv;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [12:0] v;
    int n;
    bit saw;
    repeat (3) @(negedge clk);
    chk(cmd == NOP, "R1 cmd in reset", cmd, NOP);
    chk(dqm == 0 && dq_oe == 0, "R1 dqm/oe in reset", {dqm, dq_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd == NOP && idle == 1, "R1 cmd/idle after reset", {cmd, idle}, {NOP, 1'b1});
    chk(dqm == 0 && dq_oe == 0, "R1 dqm/oe after reset", {dqm, dq_oe}, 0);

    for (int i = 0; i < 12; i++) begin
      v = VEC[i];
      cas3 = v[12]; turn_gap = v[11]; rd_len = v[10:7];
      rd_bank = 2'(i); rd_col = 9'(i * 7 + 3);
      wr_bank = ~2'(i); wr_col = 9'(i * 13 + 1); wr_data = 16'hA500 + 16'(i);
      contention = 0; invalid = 0; oe_err = 0;
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      chk(cmd == RD && ba == rd_bank && col == rd_col, "R2 READ issue", cmd, RD);
      repeat (int'(v[6:3])) @(negedge clk);
      wr_req = 1;
      @(negedge clk); wr_req = 0;
      n = 1;
      while (cmd != WR && n < 8) begin @(negedge clk); n++; end
      // R3 direct, R4/R5 preamble lengths, R8 both CAS latencies
      chk(n == int'(v[2:0]), "R3/R4/R5/R8 WRITE latency", n, int'(v[2:0]));
      chk(ba == wr_bank && col == wr_col && dq_out == wr_data && !dqm && dq_oe,
          "R6/R10 WRITE fields", {ba, col}, {wr_bank, wr_col});
      repeat (20) @(negedge clk);
      chk(contention == 0, "R7 two drivers", contention, 0);
      chk(invalid == 0, "R4 unmasked truncation", invalid, 0);
      chk(oe_err == 0, "R6 oe outside WRITE", oe_err, 0);
    end

    // R9: simultaneous requests, write first
    cas3 = 1; turn_gap = 0; rd_len = 4'd4;
    @(negedge clk); rd_req = 1; wr_req = 1;
    @(negedge clk); rd_req = 0; wr_req = 0;
    chk(cmd == WR, "R9 write priority", cmd, WR);
    saw = 0;
    repeat (5) begin @(negedge clk); if (cmd == RD) saw = 1; end
    chk(!saw, "R9 read dropped on collision", saw, 0);

    // R9: requests during preamble ignored
    rd_len = 4'd8;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0; wr_req = 1;
    @(negedge clk); wr_req = 0;
    chk(idle == 0, "R9 idle low in preamble", idle, 0);
    rd_req = 1; wr_req = 1;
    @(negedge clk); rd_req = 0; wr_req = 0;
    saw = 0; n = 0;
    repeat (6) begin @(negedge clk); if (cmd == RD) saw = 1; if (cmd == WR) n++; end
    chk(!saw && n == 1, "R9 requests ignored in preamble", n, 1);

    // R1: reset in the middle of a preamble
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0; wr_req = 1;
    @(negedge clk); wr_req = 0;
    rst_n = 0;
    #1;
    chk(cmd == NOP && !dqm && !dq_oe && idle, "R1 reset mid-preamble", {cmd, dqm}, {NOP, 1'b0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule